// File: doc/BRIEF.md
# Program Memory Byte Load Unit

This unit runs the "load one byte from program memory" instruction inside a small 8-bit processor datapath. It recognises three 16-bit instruction forms, takes a 16-bit byte pointer from register pair 31:30 (register 30 is the low byte), reads the 16-bit word that holds the byte from word-organised program memory, selects the addressed byte lane and writes it to a destination register. One form also writes the pointer back, incremented, to the register pair.

Program memory has a synchronous read port with one cycle of latency. An accepted instruction runs a fixed three-cycle sequence: address, read, writeback. Fetch stalls for all three cycles. Done is raised in the writeback cycle, and that is the cycle in which fetch advances the program counter by one word. The destination write and the pointer-pair write use separate ports and happen in the same cycle. The post-increment form with register 30 or 31 as destination gives an undefined register result. The unit flags that case and still performs both writes.

Top module: `pm_byte_load`

## Requirements
- R1: While reset is held and after it is released with no instruction offered, stall_o, done_o, pm_re_o, rd_we_o, ptr_we_o and illegal_o are all 0.
- R2: In the first cycle after an instruction is accepted, pm_re_o is 1 and pm_addr_o equals the pointer {ptr_hi_i, ptr_lo_i} shifted right by one. The pointer is sampled at acceptance. Only the 16-bit pointer is used, so only words 0 to 32767 can be reached.
- R3: The byte written is bits 7:0 of the word that was read when pointer bit 0 is 0, and bits 15:8 when pointer bit 0 is 1.
- R4: Instruction 16'h95C8 writes the byte to register 0 and raises no pointer write.
- R5: An instruction matching 1001_000d_dddd_0100 writes the byte to register d (instruction bits 8:4, 0 to 31) and raises no pointer write.
- R6: An instruction matching 1001_000d_dddd_0101 writes the byte to register d. In the same cycle, ptr_we_o is 1 and ptr_wdata_o is the pointer plus one.
- R7: The post-increment wraps within 16 bits, so pointer 16'hFFFF is written back as 16'h0000.
- R8: An accepted instruction holds stall_o at 1 for exactly three cycles. done_o and rd_we_o are 1 only in the third of them. After that cycle the unit is idle again.
- R9: An instruction word offered with instr_valid_i that matches none of the three forms is ignored: stall_o, pm_re_o, rd_we_o and ptr_we_o stay 0.
- R10: illegal_o is 1 in the writeback cycle of a post-increment instruction whose destination is register 30 or 31, and 0 for every other accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word offered |
| instr_i | input | 16 | Instruction word |
| ptr_lo_i | input | 8 | Current value of register 30 |
| ptr_hi_i | input | 8 | Current value of register 31 |
| stall_o | output | 1 | Hold fetch while the sequence runs |
| done_o | output | 1 | Last cycle of the sequence; program counter advances one word |
| pm_re_o | output | 1 | Program memory read strobe |
| pm_addr_o | output | 15 | Program memory word address |
| pm_rdata_i | input | 16 | Program memory read word, valid one cycle after the strobe |
| rd_we_o | output | 1 | Destination register write enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_wdata_o | output | 8 | Byte written to the destination |
| ptr_we_o | output | 1 | Register pair 31:30 write enable |
| ptr_wdata_o | output | 16 | Incremented pointer for register pair 31:30 |
| illegal_o | output | 1 | Post-increment with register 30 or 31 as destination |

## Verification
The three instruction forms are run with random pointers and destinations. Pointers with bit 0 set and clear separate the two byte lanes, and a memory pattern whose two bytes differ in every word exposes a swapped lane or an address that is off by one word. Directed cases use pointers 16'hFFFF and 16'hFFFE, which show whether the increment wraps or spills past 16 bits. Destinations 0 and 31 on every form show whether the implied form and the field decode are correct. Non-matching words that sit next to the valid encodings (16'h9006, 16'h95D8) check that the decode ignores them, and post-increments into registers 30 and 31 check the illegal flag.

// File: rtl/pmbl_pkg.sv
package pmbl_pkg;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned WORD_W = 2 * DATA_W;
  localparam int unsigned WADR_W = PTR_W - 1;

  localparam logic [15:0] OP_IMPL    = 16'h95C8;
  localparam logic [6:0]  OP_Z_HEAD  = 7'b1001000;
  localparam logic [3:0]  OP_Z_TAIL  = 4'b0100;
  localparam logic [3:0]  OP_ZI_TAIL = 4'b0101;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_READ, ST_WB} pmbl_state_e;
  typedef enum logic [1:0] {FORM_NONE, FORM_IMPL, FORM_Z, FORM_ZINC} pmbl_form_e;
endpackage

// File: rtl/pmbl_decode.sv
module pmbl_decode
  import pmbl_pkg::*;
(
  input  logic [15:0]       instr_i,
  output pmbl_form_e        form_o,
  output logic [REG_AW-1:0] dest_o
);
  always_comb begin
    form_o = FORM_NONE;
    dest_o = '0;
    if (instr_i == OP_IMPL) begin
      form_o = FORM_IMPL;
    end else if (instr_i[15:9] == OP_Z_HEAD) begin
      dest_o = instr_i[8:4];
      if (instr_i[3:0] == OP_Z_TAIL)       form_o = FORM_Z;
      else if (instr_i[3:0] == OP_ZI_TAIL) form_o = FORM_ZINC;
    end
  end
endmodule

// File: rtl/pmbl_seq.sv
module pmbl_seq
  import pmbl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output pmbl_state_e state_o,
  output logic        busy_o,
  output logic        re_o,
  output logic        cap_o,
  output logic        wb_o
);
  pmbl_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_IDLE: state_d = start_i ? ST_ADDR : ST_IDLE;
      ST_ADDR: state_d = ST_READ;
      ST_READ: state_d = ST_WB;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign re_o    = (state_q == ST_ADDR);
  assign cap_o   = (state_q == ST_READ);
  assign wb_o    = (state_q == ST_WB);
endmodule

// File: rtl/pmbl_lane.sv
module pmbl_lane #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [PTR_W-1:0]  ptr_next_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      byte_q <= '0;
    end else begin
      if (load_i) ptr_q <= ptr_i;
      // bit 0 of the byte pointer picks the lane
      if (cap_i)  byte_q <= ptr_q[0] ? word_i[WORD_W-1:DATA_W] : word_i[DATA_W-1:0];
    end
  end

  assign ptr_o      = ptr_q;
  assign byte_o     = byte_q;
  assign ptr_next_o = ptr_q + PTR_W'(1); // wraps, no page carry
endmodule

// File: rtl/pm_byte_load.sv
module pm_byte_load
  import pmbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] ptr_lo_i,
  input  logic [DATA_W-1:0] ptr_hi_i,
  output logic              stall_o,
  output logic              done_o,
  output logic              pm_re_o,
  output logic [WADR_W-1:0] pm_addr_o,
  input  logic [WORD_W-1:0] pm_rdata_i,
  output logic              rd_we_o,
  output logic [REG_AW-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_wdata_o,
  output logic              ptr_we_o,
  output logic [PTR_W-1:0]  ptr_wdata_o,
  output logic              illegal_o
);
  pmbl_form_e        dec_form, form_q;
  logic [REG_AW-1:0] dec_dest, dest_q;
  pmbl_state_e       state;
  logic              busy, re, cap, wb, start;
  logic [PTR_W-1:0]  ptr_q, ptr_next;

  pmbl_decode u_dec (
    .instr_i (instr_i),
    .form_o  (dec_form),
    .dest_o  (dec_dest)
  );

  assign start = instr_valid_i && (state == ST_IDLE) && (dec_form != FORM_NONE);

  pmbl_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .state_o (state),
    .busy_o  (busy),
    .re_o    (re),
    .cap_o   (cap),
    .wb_o    (wb)
  );

  pmbl_lane #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .ptr_i      ({ptr_hi_i, ptr_lo_i}),
    .cap_i      (cap),
    .word_i     (pm_rdata_i),
    .ptr_o      (ptr_q),
    .byte_o     (rd_wdata_o),
    .ptr_next_o (ptr_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      form_q <= FORM_NONE;
      dest_q <= '0;
    end else if (start) begin
      form_q <= dec_form;
      dest_q <= dec_dest;
    end
  end

  assign stall_o     = busy;
  assign done_o      = wb;
  assign pm_re_o     = re;
  assign pm_addr_o   = ptr_q[PTR_W-1:1];
  assign rd_we_o     = wb;
  assign rd_addr_o   = dest_q;
  assign ptr_we_o    = wb && (form_q == FORM_ZINC);
  assign ptr_wdata_o = ptr_next;
  // destination overlaps the pointer pair
  assign illegal_o   = ptr_we_o && (dest_q[REG_AW-1:1] == '1);
endmodule

// File: rtl/pmbl_chk.sv
module pmbl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stall_o,
  input logic done_o,
  input logic pm_re_o,
  input logic rd_we_o,
  input logic ptr_we_o,
  input logic illegal_o
);
  assert_re_in_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_re_o |-> (stall_o && !done_o));

  assert_stall_starts_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> pm_re_o);

  assert_done_after_two_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(stall_o) && $past(stall_o, 2) && !$past(done_o)));

  assert_done_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !stall_o);

  assert_wr_in_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> done_o);

  assert_ptr_with_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_o |-> (rd_we_o && done_o));

  assert_illegal_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ptr_we_o);
endmodule

bind pm_byte_load pmbl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stall_o   (stall_o),
  .done_o    (done_o),
  .pm_re_o   (pm_re_o),
  .rd_we_o   (rd_we_o),
  .ptr_we_o  (ptr_we_o),
  .illegal_o (illegal_o)
);

// File: tb/pm_byte_load_tb.sv
`timescale 1ns/1ps
module pm_byte_load_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [7:0]  ptr_lo_i = '0, ptr_hi_i = '0;
  logic        stall_o, done_o, pm_re_o, rd_we_o, ptr_we_o, illegal_o;
  logic [14:0] pm_addr_o;
  logic [15:0] pm_rdata_i = '0;
  logic [4:0]  rd_addr_o;
  logic [7:0]  rd_wdata_o;
  logic [15:0] ptr_wdata_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  pm_byte_load u_dut (.*);

  function automatic logic [15:0] pm_word(logic [14:0] a);
    logic [31:0] t;
    t = {17'd0, a} * 32'h9E37 + 32'h1234;
    return {t[15:8], t[7:0] ^ 8'h5A};
  endfunction

  always_ff @(posedge clk_i) if (pm_re_o) pm_rdata_i <= pm_word(pm_addr_o);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // form: 0 implied, 1 plain, 2 post-increment
  task automatic run_op(int form, logic [4:0] d, logic [15:0] ptr);
    logic [15:0] w, nx;
    logic [7:0]  eb;
    logic [4:0]  ed;
    w  = pm_word(ptr[15:1]);
    eb = ptr[0] ? w[15:8] : w[7:0];
    ed = (form == 0) ? 5'd0 : d;
    nx = ptr + 16'd1;
    @(negedge clk_i);
    {ptr_hi_i, ptr_lo_i} = ptr;
    instr_i = (form == 0) ? 16'h95C8 : {7'b1001000, d, (form == 2) ? 4'b0101 : 4'b0100};
    instr_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    {ptr_hi_i, ptr_lo_i} = ~ptr; // sampled at acceptance only
    chk(stall_o && pm_re_o && !done_o, "R8 addr cycle", {stall_o, pm_re_o, done_o}, 3'b110);
    chk(pm_addr_o == ptr[15:1], "R2 word address", pm_addr_o, ptr[15:1]);
    @(negedge clk_i);
    chk(stall_o && !done_o && !rd_we_o, "R8 read cycle", {stall_o, done_o, rd_we_o}, 3'b100);
    @(negedge clk_i);
    chk(stall_o && done_o && rd_we_o, "R8 writeback cycle", {stall_o, done_o, rd_we_o}, 3'b111);
    chk(rd_addr_o == ed, (form == 0) ? "R4 implied dest" : "R5 dest field", rd_addr_o, ed);
    if (!(form == 2 && d[4:1] == 4'hF))
      chk(rd_wdata_o == eb, "R3 byte lane", rd_wdata_o, eb);
    chk(ptr_we_o == (form == 2), (form == 2) ? "R6 ptr write" : "R4 R5 no ptr write", ptr_we_o, form == 2);
    if (form == 2)
      chk(ptr_wdata_o == nx, (ptr == 16'hFFFF) ? "R7 wrap" : "R6 ptr plus one", ptr_wdata_o, nx);
    chk(illegal_o == (form == 2 && d[4:1] == 4'hF), "R10 illegal flag", illegal_o,
        form == 2 && d[4:1] == 4'hF);
    @(negedge clk_i);
    chk(!stall_o && !done_o, "R8 back to idle", {stall_o, done_o}, 0);
  endtask

  task automatic run_bad(logic [15:0] op);
    @(negedge clk_i);
    instr_i = op;
    instr_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    chk(!stall_o && !pm_re_o, "R9 ignored word", {stall_o, pm_re_o}, 0);
    @(negedge clk_i);
    chk(!stall_o && !rd_we_o && !ptr_we_o, "R9 no writes", {stall_o, rd_we_o, ptr_we_o}, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk(!stall_o && !done_o && !pm_re_o && !rd_we_o && !ptr_we_o && !illegal_o,
        "R1 in reset", {stall_o, done_o, pm_re_o, rd_we_o, ptr_we_o, illegal_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!stall_o && !done_o && !pm_re_o && !rd_we_o && !ptr_we_o && !illegal_o,
        "R1 after reset", {stall_o, done_o, pm_re_o, rd_we_o, ptr_we_o, illegal_o}, 0);

    run_op(0, 5'd0, 16'h0000);
    run_op(0, 5'd0, 16'h1235);
    run_op(1, 5'd31, 16'hFFFE);
    run_op(1, 5'd0, 16'h8001);
    run_op(2, 5'd5, 16'hFFFF);
    run_op(2, 5'd29, 16'h00FF);
    run_op(2, 5'd30, 16'h4000);
    run_op(2, 5'd31, 16'h4001);
    run_bad(16'h9006);
    run_bad(16'h95D8);
    run_bad(16'h0000);
    for (int i = 0; i < 60; i++)
      run_op($urandom_range(0, 2), 5'($urandom_range(0, 31)), 16'($urandom));
    finished = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule